// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block controls a 10-bit successive-approximation converter. Software starts a conversion with a one-cycle request pulse. The block then stops the sample phase and picks the conversion clock chosen by a 2-bit select field. That clock is either a divided copy of the system clock or the pulses of a separate RC timebase. The block then searches for the input value one trial bit at a time, starting from the most significant bit, and steers the search with a single comparator bit.

The comparator, the hold capacitor and the RC oscillator are all outside the block. The comparator is a plain input bit. The RC oscillator is a strobe input, `rc_tick`, that is synchronous to `clk`. A conversion takes eleven conversion periods: one setup period and then one period per bit. At the end the result register is loaded once, the sticky interrupt flag is set, the busy bit drops and sampling resumes. Software can abort a conversion by clearing the busy bit.

Result and flag are plain status outputs. Software reads them whenever it likes, so there is no stream and no back-pressure at this block's edge.

Top module: `sar_seq`

## Requirements
- R1: A `go_set` pulse while `busy` is low raises `busy` and lowers `sampling` on the next clock edge.
- R2: The select values 0, 1 and 2 give conversion periods of 2, 8 and 32 clocks. The result is loaded exactly 11 periods after the start edge, and `busy` is still high one clock earlier.
- R3: Select value 3 uses the RC strobe. The block first waits 4 clocks (one instruction cycle) after the start edge. Strobes during that wait are ignored and leave `dac_code` at 0. Eleven counted strobes after it complete the conversion.
- R4: The result is the binary search of the input, MSB first (bit 9 to bit 0). A trial bit is kept when `cmp_in` is 1 (input at or above `dac_code`) and cleared when it is 0. With an ideal comparator the result equals the input code.
- R5: `result` holds its previous value for the whole conversion and changes only on the completion edge. On that same edge `irq_flag` sets, `busy` falls and `sampling` rises.
- R6: `irq_flag` stays set until a `flag_clr` pulse clears it.
- R7: A `go_clr` pulse while `busy` is high aborts the conversion. On the next edge `busy` is 0 and `sampling` is 1. `result` and `irq_flag` stay unchanged, then and later.
- R8: A `go_set` pulse while `busy` is high is ignored. The running conversion finishes with its original timing and result.
- R9: Reset gives `busy`=0, `sampling`=1, `result`=0, `irq_flag`=0 and `dac_code`=0.
- R10: The first conversion period is setup. After it, `dac_code` is 0x200 (only the MSB trial bit set).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_sel | input | 2 | Conversion clock select, latched at start (0:/2, 1:/8, 2:/32, 3:RC) |
| go_set | input | 1 | Software write of 1 to the busy bit (start) |
| go_clr | input | 1 | Software write of 0 to the busy bit (abort) |
| flag_clr | input | 1 | Software clear of the interrupt flag |
| rc_tick | input | 1 | One-clock strobe per RC oscillator period |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above `dac_code` |
| busy | output | 1 | Busy bit (reads as the software GO bit) |
| sampling | output | 1 | High while the hold capacitor tracks the input |
| dac_code | output | 10 | Current trial code to the DAC |
| result | output | 10 | Conversion result register |
| irq_flag | output | 1 | Sticky conversion-complete flag |

## Verification
In divided modes the result is due exactly 11 x divisor clocks after the start edge. The setup code 0x200 is due one divisor later than the start edge. The bench counts those edges and samples on the falling edge just before and just after the completion edge, so an off-by-one period in either direction is caught. In RC mode the bench produces every strobe itself. It places one strobe inside the 4-clock wait and checks that the trial code is still 0 after the wait. It then counts eleven strobes, checking the old result after the tenth and the new one after the eleventh. The abort and ignored-start cases are sampled on the first falling edge after the pulse. They are then sampled again past the time the conversion would have finished.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_CONV = 2'd2
  } seq_state_e;

  localparam logic [1:0] SEL_RC = 2'b11;
endpackage

// File: rtl/sar_tick_gen.sv
module sar_tick_gen
  import sar_seq_pkg::*;
#(
  parameter int DIV0 = 2,
  parameter int DIV1 = 8,
  parameter int DIV2 = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] clk_sel,
  input  logic       rc_tick,
  output logic       tick
);
  localparam int MAXDIV01 = (DIV0 > DIV1) ? DIV0 : DIV1;
  localparam int MAXDIV   = (MAXDIV01 > DIV2) ? MAXDIV01 : DIV2;
  localparam int CW       = (MAXDIV > 2) ? $clog2(MAXDIV) : 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          div_hit;

  always_comb begin
    case (clk_sel)
      2'd0:    lim = CW'(DIV0 - 1);
      2'd1:    lim = CW'(DIV1 - 1);
      default: lim = CW'(DIV2 - 1);
    endcase
  end

  assign div_hit = (cnt == lim);

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt <= '0;
    else if (!run || div_hit) cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end

  assign tick = run & ((clk_sel == SEL_RC) ? rc_tick : div_hit);
endmodule

// File: rtl/sar_bit_reg.sv
module sar_bit_reg #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         setup,
  input  logic         decide,
  input  logic         cmp,
  output logic [W-1:0] code,
  output logic [W-1:0] code_next
);
  localparam logic [W-1:0] MSB_ONLY = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] ptr;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == W - 1) begin : g_top
      assign code_next[i] = ptr[i] ? (code[i] & cmp) : code[i];
    end else begin : g_low
      assign code_next[i] = ptr[i] ? (code[i] & cmp) : (code[i] | ptr[i+1]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      code <= '0;
      ptr  <= '0;
    end else if (setup) begin
      code <= MSB_ONLY;
      ptr  <= MSB_ONLY;
    end else if (decide) begin
      code <= code_next;
      ptr  <= ptr >> 1;
    end
  end
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS = 10,
  parameter int TCY_CLKS = 4,
  parameter int DIV0     = 2,
  parameter int DIV1     = 8,
  parameter int DIV2     = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          clk_sel,
  input  logic                go_set,
  input  logic                go_clr,
  input  logic                flag_clr,
  input  logic                rc_tick,
  input  logic                cmp_in,
  output logic                busy,
  output logic                sampling,
  output logic [RES_BITS-1:0] dac_code,
  output logic [RES_BITS-1:0] result,
  output logic                irq_flag
);
  localparam int STEPS = RES_BITS + 1;
  localparam int SW    = $clog2(STEPS + 1);
  localparam int TW    = (TCY_CLKS > 2) ? $clog2(TCY_CLKS) : 1;

  seq_state_e          state;
  logic [1:0]          sel_q;
  logic [SW-1:0]       step;
  logic [TW-1:0]       dcnt;
  logic                tick, start, abort, setup, decide, done;
  logic [RES_BITS-1:0] code_next;

  assign start  = (state == ST_IDLE) && go_set;
  assign abort  = (state != ST_IDLE) && go_clr;
  assign setup  = tick && (step == '0) && !abort;
  assign decide = tick && (step != '0) && !abort;
  assign done   = decide && (step == SW'(RES_BITS));

  sar_tick_gen #(.DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (state == ST_CONV),
    .clk_sel (sel_q),
    .rc_tick (rc_tick),
    .tick    (tick)
  );

  sar_bit_reg #(.W(RES_BITS)) u_bits (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start),
    .setup     (setup),
    .decide    (decide),
    .cmp       (cmp_in),
    .code      (dac_code),
    .code_next (code_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      sel_q    <= '0;
      step     <= '0;
      dcnt     <= '0;
      busy     <= 1'b0;
      sampling <= 1'b1;
      result   <= '0;
      irq_flag <= 1'b0;
    end else begin
      if (done)          irq_flag <= 1'b1;
      else if (flag_clr) irq_flag <= 1'b0;

      case (state)
        ST_IDLE: begin
          if (start) begin
            busy     <= 1'b1;
            sampling <= 1'b0;
            step     <= '0;
            dcnt     <= '0;
            sel_q    <= clk_sel;
            state    <= (clk_sel == SEL_RC) ? ST_HOLD : ST_CONV;
          end
        end
        ST_HOLD: begin
          if (abort) begin
            busy     <= 1'b0;
            sampling <= 1'b1;
            state    <= ST_IDLE;
          end else if (dcnt == TW'(TCY_CLKS - 1)) begin
            state <= ST_CONV;
          end else begin
            dcnt <= dcnt + 1'b1;
          end
        end
        ST_CONV: begin
          if (abort) begin
            busy     <= 1'b0;
            sampling <= 1'b1;
            state    <= ST_IDLE;
          end else if (tick) begin
            step <= step + 1'b1;
            if (done) begin
              result   <= code_next;
              busy     <= 1'b0;
              sampling <= 1'b1;
              state    <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int RES_BITS = 10
) (
  input logic                clk,
  input logic                rst_n,
  input logic                go_set,
  input logic                go_clr,
  input logic                flag_clr,
  input logic                busy,
  input logic                sampling,
  input logic [RES_BITS-1:0] result,
  input logic                irq_flag
);
  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && go_set) |=> (busy && !sampling)); // R1

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(result)); // R5

  AST_RESULT_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> ($fell(busy) && irq_flag)); // R5

  AST_FLAG_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> ($fell(busy) && sampling)); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !flag_clr) |=> irq_flag); // R6

  AST_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && go_clr) |=> (!busy && sampling && $stable(result))); // R7
endmodule

bind sar_seq sar_seq_chk #(.RES_BITS(RES_BITS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .go_set   (go_set),
  .go_clr   (go_clr),
  .flag_clr (flag_clr),
  .busy     (busy),
  .sampling (sampling),
  .result   (result),
  .irq_flag (irq_flag)
);

// File: tb/sar_seq_bench.sv
`timescale 1ns/1ps
module sar_seq_bench;
  localparam int NVEC = 6;
  localparam logic [11:0] VEC [NVEC] = '{
    {2'd0, 10'h000}, {2'd1, 10'h3FF}, {2'd2, 10'h2AA},
    {2'd0, 10'h155}, {2'd1, 10'h200}, {2'd0, 10'h1FF}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] clk_sel = 2'd0;
  logic       go_set = 1'b0, go_clr = 1'b0, flag_clr = 1'b0, rc_tick = 1'b0;
  logic [9:0] vin = '0;
  logic       cmp_in;
  logic       busy, sampling, irq_flag;
  logic [9:0] dac_code, result;
  logic [9:0] prev_res;
  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  assign cmp_in = (vin >= dac_code);

  sar_seq u_sar_seq (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .go_set(go_set),
    .go_clr(go_clr), .flag_clr(flag_clr), .rc_tick(rc_tick), .cmp_in(cmp_in),
    .busy(busy), .sampling(sampling), .dac_code(dac_code),
    .result(result), .irq_flag(irq_flag)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int div_of(input logic [1:0] s);
    return (s == 2'd0) ? 2 : (s == 2'd1) ? 8 : 32;
  endfunction

  task automatic start_go();
    @(negedge clk) go_set = 1'b1;
    @(posedge clk);
    @(negedge clk) go_set = 1'b0;
  endtask

  task automatic clear_flag();
    @(negedge clk) flag_clr = 1'b1;
    @(posedge clk);
    @(negedge clk) flag_clr = 1'b0;
  endtask

  task automatic rc_pulse();
    @(negedge clk) rc_tick = 1'b1;
    @(posedge clk);
    @(negedge clk) rc_tick = 1'b0;
    @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 busy", busy, 0);
    chk("R9 sampling", sampling, 1);
    chk("R9 result", result, 0);
    chk("R9 flag", irq_flag, 0);
    chk("R9 dac", dac_code, 0);
    rst_n = 1'b1;
    prev_res = '0;

    for (int v = 0; v < NVEC; v++) begin
      int d;
      clk_sel = VEC[v][11:10];
      vin = VEC[v][9:0];
      d = div_of(clk_sel);
      clear_flag();
      chk("R6 flag cleared", irq_flag, 0);
      start_go();
      chk("R1 busy after start", busy, 1);
      chk("R1 sampling stopped", sampling, 0);
      repeat (d) @(posedge clk);
      @(negedge clk);
      chk("R10 setup code", dac_code, 10'h200);
      repeat (10 * d - 1) @(posedge clk);
      @(negedge clk);
      chk("R2 busy before end", busy, 1);
      chk("R5 result held", result, prev_res);
      @(posedge clk);
      @(negedge clk);
      chk("R4 result value", result, vin);
      chk("R5 busy cleared", busy, 0);
      chk("R5 flag set", irq_flag, 1);
      chk("R5 sampling resumed", sampling, 1);
      prev_res = vin;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R6 flag sticky", irq_flag, 1);
    end

    // R3: RC mode with a strobe inside the one-cycle wait
    clk_sel = 2'd3;
    vin = 10'h2C7;
    clear_flag();
    start_go();
    @(posedge clk);
    @(negedge clk) rc_tick = 1'b1;
    @(posedge clk);
    @(negedge clk) rc_tick = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R3 strobe in wait ignored", dac_code, 0);
    rc_pulse();
    @(negedge clk);
    chk("R3 first strobe is setup", dac_code, 10'h200);
    for (int k = 0; k < 9; k++) rc_pulse();
    @(negedge clk);
    chk("R3 busy after ten strobes", busy, 1);
    chk("R3 result held", result, prev_res);
    rc_pulse();
    @(negedge clk);
    chk("R3 result after eleven", result, vin);
    chk("R3 busy cleared", busy, 0);
    prev_res = vin;

    // R7: abort
    clk_sel = 2'd1;
    vin = 10'h0F0;
    clear_flag();
    start_go();
    repeat (30) @(posedge clk);
    @(negedge clk) go_clr = 1'b1;
    @(posedge clk);
    @(negedge clk) go_clr = 1'b0;
    chk("R7 busy low", busy, 0);
    chk("R7 sampling high", sampling, 1);
    chk("R7 result kept", result, prev_res);
    chk("R7 flag not set", irq_flag, 0);
    repeat (100) @(posedge clk);
    @(negedge clk);
    chk("R7 result still kept", result, prev_res);
    chk("R7 flag still clear", irq_flag, 0);

    // R8: start request during conversion ignored
    clk_sel = 2'd0;
    vin = 10'h31C;
    start_go();
    repeat (5) @(posedge clk);
    @(negedge clk) go_set = 1'b1;
    @(posedge clk);
    @(negedge clk) go_set = 1'b0;
    repeat (15) @(posedge clk);
    @(negedge clk);
    chk("R8 busy before end", busy, 1);
    chk("R8 result held", result, prev_res);
    @(posedge clk);
    @(negedge clk);
    chk("R8 result on time", result, vin);
    chk("R8 busy cleared", busy, 0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R8 no restart", busy, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule